// File: doc/BRIEF.md
# Multi-Channel Down-Counting Timer Unit

This block is a register-mapped timer unit. It has three reloadable down-counters and one wide free-running up-counter. Two clock-enable inputs supply the counting rates: a slow tick and a fast tick. Each down-counter has four registers: a load register, a value readback, a control register and an interrupt-clear register. A down-counter in periodic mode raises its own interrupt line when it underflows, then reloads itself from its load register. The first two channels are 16 bits wide and the third is 32 bits wide. The fourth channel is a 40-bit up-counter that runs on the fast tick and never interrupts. Its count is read as a low word and a high word, and its run flag lives in the high word.

Software sets up a periodic channel in three writes. It first writes the control register with the enable bit clear, then writes the load value, then writes the control register again with the enable bit set. A load value of N-1 gives one interrupt every N ticks. The register bus takes one transfer per cycle. A write takes effect at the clock edge that samples it. Read data appears on the cycle after the request.

Top module: `timer_unit`

## Requirements
- R1: After reset, every interrupt line is low. Every counter, load register and control register reads zero, and bus_rdata is zero.
- R2: Word addresses on bus_addr are laid out as follows for channel c (0..2): base c*4, load at +0, value at +1, control at +2, clear at +3. The free-running counter's low word is at 12 and its high word at 13. Channels 0 and 1 are 16 bits wide and channel 2 is 32 bits wide. In non-periodic mode a channel wraps from 0 to all ones for its width (0xFFFF or 0xFFFFFFFF).
- R3: In periodic mode with load value N-1, the interrupt line rises on the Nth selected tick after enabling. On that same tick the counter reloads N-1.
- R4: In non-periodic mode an underflow never raises the channel's interrupt.
- R5: A write of any data to a channel's clear register drops that channel's interrupt on the next cycle. If an underflow lands in the same cycle as the clear write, the interrupt stays high.
- R6: Control bit 7 enables the channel and bit 6 selects periodic mode. Bit 3 selects the tick: 1 counts on tick_slow and 0 counts on tick_fast. A read of the control register returns only these three bits, with all other bits zero.
- R7: A load write while the channel is enabled leaves the count unchanged until the next selected tick. On that tick the count becomes the new load value, without decrementing.
- R8: A load write while the channel is disabled sets the count to the load value at once.
- R9: Writing the high-word register sets the free-running counter's run flag from data bit 8. While the flag is set, the 40-bit count rises by one on each tick_fast. The free-running counter never drives an interrupt.
- R10: A read of the low word returns count bits 31:0. A read of the high word returns count bits 39:32 in bits 7:0 and the run flag in bit 8. Read data appears on bus_rdata the cycle after the read request and holds until the next read.
- R11: A disabled channel holds its count whatever the ticks do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_slow | input | 1 | Slow counting enable, one cycle per tick |
| tick_fast | input | 1 | Fast counting enable, one cycle per tick |
| bus_sel | input | 1 | Register transfer request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 3 | Per-channel interrupt lines, bit c for channel c |

## Verification
The bench counts a periodic channel through the exact N ticks that a load of N-1 implies. A design off by one would raise the interrupt a tick early or a tick late, or would reload to the wrong value. The bench drives a clear write and an underflow into the same cycle. A design that gives the clear priority would lose that interrupt. The bench also rewrites the load register while a channel is running. A design that reloads at once, or that decrements the new value on the following tick, shows the wrong count. Further checks cover wrap to all ones at both channel widths, the tick-select bit, and the free-running counter staying still until its run flag is set. A width or select bug shows up there as a wrong readback value.

// File: rtl/timer_unit_pkg.sv
package timer_unit_pkg;
  localparam int CTL_EN_BIT   = 7;
  localparam int CTL_PER_BIT  = 6;
  localparam int CTL_SLOW_BIT = 3;
  localparam int FREE_RUN_BIT = 8;
  localparam logic [1:0] OFS_LOAD  = 2'd0;
  localparam logic [1:0] OFS_VALUE = 2'd1;
  localparam logic [1:0] OFS_CTRL  = 2'd2;
  localparam logic [1:0] OFS_CLEAR = 2'd3;
endpackage

// File: rtl/timer_dn_chan.sv
module timer_dn_chan #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_slow,
  input  logic         tick_fast,
  input  logic         wr_load,
  input  logic         wr_ctrl,
  input  logic         wr_clr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] load_o,
  output logic [2:0]   ctrl_o,
  output logic         irq_o
);
  import timer_unit_pkg::*;

  logic         en_q, per_q, slow_q, pend_q, irq_q;
  logic [W-1:0] cnt_q, load_q;
  logic         step, under;

  assign step  = en_q & (slow_q ? tick_slow : tick_fast);
  assign under = step & ~pend_q & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      per_q  <= 1'b0;
      slow_q <= 1'b0;
      pend_q <= 1'b0;
      cnt_q  <= '0;
      load_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q   <= wdata[CTL_EN_BIT];
        per_q  <= wdata[CTL_PER_BIT];
        slow_q <= wdata[CTL_SLOW_BIT];
      end
      if (step) begin
        pend_q <= 1'b0;
        if (pend_q)             cnt_q <= load_q;
        else if (cnt_q == '0)   cnt_q <= per_q ? load_q : '1;
        else                    cnt_q <= cnt_q - 1'b1;
      end
      if (wr_load) begin
        load_q <= wdata;
        pend_q <= en_q;
        if (!en_q) cnt_q <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                 irq_q <= 1'b0;
    else if (under && per_q) irq_q <= 1'b1;
    else if (wr_clr)         irq_q <= 1'b0;
  end

  assign cnt_o  = cnt_q;
  assign load_o = load_q;
  assign ctrl_o = {en_q, per_q, slow_q};
  assign irq_o  = irq_q;
endmodule

// File: rtl/timer_free_cnt.sv
module timer_free_cnt #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         wr_run,
  input  logic         run_val,
  output logic [W-1:0] cnt_o,
  output logic         run_o
);
  logic [W-1:0] cnt_q;
  logic         run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (wr_run)        run_q <= run_val;
      if (run_q && tick) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign run_o = run_q;
endmodule

// File: rtl/timer_unit.sv
module timer_unit #(
  parameter int NCH      = 3,
  parameter int W_NARROW = 16,
  parameter int W_WIDE   = 32,
  parameter logic [NCH-1:0] WIDE_SEL = 3'b100,
  parameter int DW       = 32,
  parameter int FW       = 40,
  parameter int ADDR_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_slow,
  input  logic              tick_fast,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  output logic [NCH-1:0]    irq
);
  import timer_unit_pkg::*;

  localparam int FREE_LO_A = NCH * 4;
  localparam int FREE_HI_A = NCH * 4 + 1;

  logic                     we;
  logic [ADDR_W-3:0]        ch_idx;
  logic [1:0]               ch_ofs;
  logic [NCH-1:0][DW-1:0]   chan_cnt;
  logic [NCH-1:0][DW-1:0]   chan_load;
  logic [NCH-1:0][DW-1:0]   chan_ctrl;
  logic [FW-1:0]            fcnt;
  logic                     frun;
  logic [DW-1:0]            free_hi;
  logic [DW-1:0]            rd_mux;

  assign we     = bus_sel & bus_wr;
  assign ch_idx = bus_addr[ADDR_W-1:2];
  assign ch_ofs = bus_addr[1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int CW = WIDE_SEL[c] ? W_WIDE : W_NARROW;
    logic          hit;
    logic [CW-1:0] cnt_w, load_w;
    logic [2:0]    ctl_w;
    assign hit = we && (int'(ch_idx) == c);
    timer_dn_chan #(.W(CW)) u_chan (
      .clk       (clk),
      .rst       (rst),
      .tick_slow (tick_slow),
      .tick_fast (tick_fast),
      .wr_load   (hit && ch_ofs == OFS_LOAD),
      .wr_ctrl   (hit && ch_ofs == OFS_CTRL),
      .wr_clr    (hit && ch_ofs == OFS_CLEAR),
      .wdata     (bus_wdata[CW-1:0]),
      .cnt_o     (cnt_w),
      .load_o    (load_w),
      .ctrl_o    (ctl_w),
      .irq_o     (irq[c])
    );
    assign chan_cnt[c]  = DW'(cnt_w);
    assign chan_load[c] = DW'(load_w);
    always_comb begin
      chan_ctrl[c]               = '0;
      chan_ctrl[c][CTL_EN_BIT]   = ctl_w[2];
      chan_ctrl[c][CTL_PER_BIT]  = ctl_w[1];
      chan_ctrl[c][CTL_SLOW_BIT] = ctl_w[0];
    end
  end

  timer_free_cnt #(.W(FW)) u_free (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick_fast),
    .wr_run  (we && bus_addr == ADDR_W'(FREE_HI_A)),
    .run_val (bus_wdata[FREE_RUN_BIT]),
    .cnt_o   (fcnt),
    .run_o   (frun)
  );

  always_comb begin
    free_hi                 = '0;
    free_hi[FW-DW-1:0]      = fcnt[FW-1:DW];
    free_hi[FREE_RUN_BIT]   = frun;
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NCH; c++) begin
      if (int'(ch_idx) == c) begin
        case (ch_ofs)
          OFS_LOAD:  rd_mux = chan_load[c];
          OFS_VALUE: rd_mux = chan_cnt[c];
          OFS_CTRL:  rd_mux = chan_ctrl[c];
          default:   rd_mux = '0;
        endcase
      end
    end
    if (bus_addr == ADDR_W'(FREE_LO_A)) rd_mux = fcnt[DW-1:0];
    if (bus_addr == ADDR_W'(FREE_HI_A)) rd_mux = free_hi;
  end

  always_ff @(posedge clk) begin
    if (rst)                   bus_rdata <= '0;
    else if (bus_sel && !bus_wr) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/timer_unit_chk.sv
module timer_unit_chk #(
  parameter int NCH    = 3,
  parameter int DW     = 32,
  parameter int FW     = 40,
  parameter int ADDR_W = 4
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   tick_slow,
  input logic                   tick_fast,
  input logic                   bus_sel,
  input logic                   bus_wr,
  input logic [ADDR_W-1:0]      bus_addr,
  input logic [NCH-1:0]         irq,
  input logic [NCH-1:0][DW-1:0] chan_cnt,
  input logic [FW-1:0]          fcnt
);
  for (genvar c = 0; c < NCH; c++) begin : g_a
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(c * 4 + 3);

    assert_irq_needs_tick_R3: assert property (@(posedge clk) disable iff (rst)
      $rose(irq[c]) |-> $past(tick_slow || tick_fast));

    assert_clear_drops_R5: assert property (@(posedge clk) disable iff (rst)
      (bus_sel && bus_wr && bus_addr == CLR_A && !tick_slow && !tick_fast) |=> !irq[c]);

    assert_idle_holds_R11: assert property (@(posedge clk) disable iff (rst)
      (!tick_slow && !tick_fast && !(bus_sel && bus_wr)) |=> $stable(chan_cnt[c]));
  end

  assert_free_needs_fast_R9: assert property (@(posedge clk) disable iff (rst)
    !tick_fast |=> $stable(fcnt));
endmodule

bind timer_unit timer_unit_chk #(.NCH(NCH), .DW(DW), .FW(FW), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .tick_slow (tick_slow),
  .tick_fast (tick_fast),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .irq       (irq),
  .chan_cnt  (chan_cnt),
  .fcnt      (fcnt)
);

// File: tb/timer_unit_tb.sv
module timer_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick_slow = 1'b0, tick_fast = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  timer_unit u_dut (
    .clk(clk), .rst(rst), .tick_slow(tick_slow), .tick_fast(tick_fast),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); d = bus_rdata; bus_sel = 0;
  endtask

  task automatic tk(input logic s, input logic f, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick_slow = s; tick_fast = f;
      @(negedge clk); tick_slow = 0; tick_fast = 0;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    chk("R1 irq", {29'd0, irq}, 32'd0);
    chk("R1 rdata", bus_rdata, 32'd0);
    rd(4'd1, v);  chk("R1 ch0 value", v, 0);
    rd(4'd10, v); chk("R1 ch2 ctrl", v, 0);
    rd(4'd8, v);  chk("R1 ch2 load", v, 0);
  endtask

  task automatic t_periodic();
    logic [31:0] v;
    wr(4'd2, 32'h48); wr(4'd0, 32'd4); wr(4'd2, 32'hC8);
    tk(1, 0, 4);
    chk("R3 no irq before Nth tick", {31'd0, irq[0]}, 0);
    rd(4'd1, v); chk("R3 count at zero", v, 0);
    tk(1, 0, 1);
    chk("R3 irq on Nth tick", {31'd0, irq[0]}, 1);
    rd(4'd1, v); chk("R3 reload value", v, 4);
    wr(4'd3, 32'h55);
    chk("R5 clear drops irq", {31'd0, irq[0]}, 0);
    tk(1, 0, 4);
    @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = 4'd3; tick_slow = 1;
    @(negedge clk); bus_sel = 0; bus_wr = 0; tick_slow = 0;
    chk("R5 underflow beats clear", {31'd0, irq[0]}, 1);
    wr(4'd3, 0); wr(4'd2, 0);
    chk("R5 cleared again", {31'd0, irq[0]}, 0);
  endtask

  task automatic t_ctrl();
    logic [31:0] v;
    wr(4'd2, 32'hFFFF_FF37); rd(4'd2, v); chk("R6 unused ctrl bits read zero", v, 0);
    wr(4'd2, 32'h48); rd(4'd2, v); chk("R6 ctrl readback", v, 32'h48);
    wr(4'd2, 0);
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    wr(4'd6, 32'h08); wr(4'd4, 32'd2); wr(4'd6, 32'h88);
    tk(1, 0, 3);
    rd(4'd5, v); chk("R2 16-bit wrap", v, 32'hFFFF);
    chk("R4 no irq non-periodic", {31'd0, irq[1]}, 0);
    tk(1, 0, 1);
    rd(4'd5, v); chk("R2 count after wrap", v, 32'hFFFE);
    wr(4'd10, 32'h08); wr(4'd8, 0); wr(4'd10, 32'h88);
    tk(1, 0, 1);
    rd(4'd9, v); chk("R2 32-bit wrap", v, 32'hFFFF_FFFF);
    chk("R4 no irq ch2", {31'd0, irq[2]}, 0);
    wr(4'd6, 0); wr(4'd10, 0);
  endtask

  task automatic t_select();
    logic [31:0] v;
    wr(4'd4, 32'd10);
    rd(4'd5, v); chk("R8 disabled load sets count", v, 10);
    wr(4'd6, 32'h80);
    tk(1, 0, 1); rd(4'd5, v); chk("R6 fast-select ignores slow tick", v, 10);
    tk(0, 1, 1); rd(4'd5, v); chk("R6 fast-select counts fast tick", v, 9);
    wr(4'd6, 0);
    tk(1, 1, 3); rd(4'd5, v); chk("R11 disabled holds", v, 9);
  endtask

  task automatic t_reload();
    logic [31:0] v;
    wr(4'd8, 32'd100); wr(4'd10, 32'hC8);
    tk(1, 0, 1); rd(4'd9, v); chk("R7 running count", v, 99);
    wr(4'd8, 32'd50);
    rd(4'd9, v); chk("R7 no change before tick", v, 99);
    tk(1, 0, 1); rd(4'd9, v); chk("R7 new load on tick", v, 50);
    tk(1, 0, 1); rd(4'd9, v); chk("R7 decrement after reload", v, 49);
    wr(4'd10, 0);
  endtask

  task automatic t_free();
    logic [31:0] v;
    rd(4'd12, v); chk("R9 stopped until run flag", v, 0);
    wr(4'd13, 32'h100);
    tk(0, 1, 7);
    rd(4'd12, v); chk("R10 low word", v, 7);
    rd(4'd13, v); chk("R10 high word", v, 32'h100);
    chk("R9 no irq", {29'd0, irq}, 0);
    wr(4'd13, 0);
    tk(0, 1, 2);
    rd(4'd12, v); chk("R9 stops when flag cleared", v, 7);
    chk("R10 rdata holds", bus_rdata, 7);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_periodic();
    t_ctrl();
    t_wrap();
    t_select();
    t_reload();
    t_free();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule